// File: doc/BRIEF.md
# Filtered Output-Disable Request Detector

This block watches a group of active-low emergency request pins on behalf of a set of output pins that have to be placed in high impedance when something goes wrong. It runs on the peripheral clock. Each pin first passes through a two-stage synchronizer. A per-pin mode then picks how a request is recognised. In edge mode a single falling edge is enough. In one of three filtered modes, the pin is sampled on a strobe from a shared free-running prescaler, and a request is accepted only once a full run of consecutive samples has been low. An accepted request sets a sticky per-pin flag. While any flag is set, the high-impedance request output is driven. When an enable bit is also set, the interrupt output is driven as well.

Software reaches the block through a single control/status word. A flag can only be cleared by the usual two-step handshake: read the flag as 1, then write 0 to it. In the filtered modes there is one more condition. The clear completes only once the pin has been sampled high again. A clear written while the pin is still low stays pending until that happens.

Each pin runs a four-state controller. The states are:
- WATCH: the flag is clear and the detector is armed.
- HELD: the flag is set and the pin has not yet been sampled high.
- RELEASED: the flag is set and may be cleared at once.
- CLR_PEND: a clear has been accepted and waits for a high sample.

The transitions are:
- WATCH to RELEASED on a falling edge in edge mode.
- WATCH to HELD on the final low sample of the run.
- HELD to RELEASED on a high sample.
- HELD to CLR_PEND on a clear with no high sample in that cycle.
- HELD to WATCH on a clear that coincides with a high sample.
- RELEASED to WATCH on a clear.
- CLR_PEND to WATCH on a high sample.

Top module: `odr_detect`

## Requirements
- R1: After reset the control/status word reads 0 (all flags clear, interrupt disabled, every pin in edge mode), and both `irq` and `hiz_req` are low.
- R2: Word layout for 4 pins: bits [3:0] are the flags (pin i at bit i), bit 4 is the interrupt enable, bits [7:5] are reserved, and bits [9+2i:8+2i] are the mode of pin i. Mode 00 sets the pin's flag on a falling edge of the synchronized pin, and a low pulse one clock long is enough.
- R3: Mode 01, 10 or 11 sets the flag only after 16 consecutive low samples, taken at the clock divided by 8, 16 or 128 respectively. With 15 or fewer low samples the flag is not set.
- R4: In a filtered mode, a high sample returns the low-sample count to zero, so two low stretches separated by a high sample do not add up.
- R5: Writing 0 to a flag bit clears that flag only if the flag was read as 1 since the previous write. A write of 0 with no such read leaves the flag set, and writing 1 to a flag bit never changes it.
- R6: In a filtered mode, a valid clear takes effect only after the pin has been sampled high. A clear written while the pin is still low keeps the flag set until the next high sample, and then the flag clears without a further write.
- R7: `irq` is high exactly when the enable bit is 1 and at least one flag is set.
- R8: `hiz_req` is high while any flag is set, and it falls at the same clock edge that clears the last flag.
- R9: Reserved bits read as 0, and writing 1 to them has no effect.
- R10: A write to a pin's mode field is ignored while that pin's flag is set. A mode change resets that pin's sample count and edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | N_PINS | Active-low request pins, asynchronous |
| reg_rd | input | 1 | Read strobe for the control/status word |
| reg_wr | input | 1 | Write strobe for the control/status word |
| reg_wdata | input | 4*N_PINS | Write data |
| reg_rdata | output | 4*N_PINS | Current contents of the control/status word |
| irq | output | 1 | Interrupt request |
| hiz_req | output | 1 | High-impedance request for the guarded outputs |

## Verification
The hardest situation to reach is a clear that arrives while a filtered pin is still low, which should leave the flag stuck in CLR_PEND. To get there, the stimulus holds the pin low past the 16-sample run and keeps it low. It then reads the flag and writes 0. It waits several sample periods and confirms the flag is still set. Only after that does it release the pin and expect the flag to drop on its own. The other hard case is the filter boundary. For each divider, the stimulus holds the pin low just short of 16 possible sample strobes and then just past them, which brackets the threshold no matter what phase the free-running prescaler is in.

// File: rtl/odr_pkg.sv
package odr_pkg;

    localparam logic [1:0] MODE_EDGE = 2'b00;
    localparam logic [1:0] MODE_DIV_A = 2'b01;
    localparam logic [1:0] MODE_DIV_B = 2'b10;
    localparam logic [1:0] MODE_DIV_C = 2'b11;

    localparam int N_RATES = 3;

    typedef enum logic [1:0] {
        CH_WATCH    = 2'd0,
        CH_HELD     = 2'd1,
        CH_RELEASED = 2'd2,
        CH_CLR_PEND = 2'd3
    } ch_state_t;

endpackage

// File: rtl/odr_prescaler.sv
module odr_prescaler #(
    parameter int DIV_A = 8,
    parameter int DIV_B = 16,
    parameter int DIV_C = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] stb
);
    // All dividers are powers of two and DIV_C is the largest one.
    localparam int PW = (DIV_C > 1) ? $clog2(DIV_C) : 1;
    localparam int DIVS [3] = '{DIV_A, DIV_B, DIV_C};

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    for (genvar k = 0; k < 3; k++) begin : g_tap
        localparam logic [PW-1:0] MASK = PW'(DIVS[k] - 1);
        assign stb[k] = ((cnt_q & MASK) == MASK);
    end

endmodule

// File: rtl/odr_sync.sv
module odr_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    // Reset to all ones: the pins are active low, so idle is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '1;
            s2_q <= '1;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;

endmodule

// File: rtl/odr_channel.sv
module odr_channel
    import odr_pkg::*;
#(
    parameter int RUN_LEN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       mode_chg,
    input  logic       pin_s,
    input  logic [2:0] stb,
    input  logic       clr_req,
    output logic       flag,
    output logic       smp_stb
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);
    localparam logic [CW-1:0] SAT  = CW'(RUN_LEN);

    ch_state_t     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          prev_q, prev_d;
    logic          lvl_mode, fall, smp_lo, smp_hi;

    // Pick the sample strobe that belongs to the current mode.
    always_comb begin
        unique case (mode)
            MODE_EDGE:  smp_stb = 1'b0;
            MODE_DIV_A: smp_stb = stb[0];
            MODE_DIV_B: smp_stb = stb[1];
            MODE_DIV_C: smp_stb = stb[2];
        endcase
    end

    assign lvl_mode = (mode != MODE_EDGE);
    assign fall     = prev_q & ~pin_s;
    assign smp_lo   = smp_stb & ~pin_s;
    assign smp_hi   = smp_stb & pin_s;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CH_WATCH;
            cnt_q  <= '0;
            prev_q <= 1'b1;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            prev_q <= prev_d;
        end
    end

    // Next-state logic.
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        prev_d = mode_chg ? 1'b0 : pin_s;
        unique case (st_q)
            CH_WATCH: begin
                if (mode_chg) begin
                    cnt_d = '0;
                end else if (!lvl_mode) begin
                    if (fall) st_d = CH_RELEASED;
                end else if (smp_hi) begin
                    cnt_d = '0;
                end else if (smp_lo) begin
                    if (cnt_q == LAST) begin
                        st_d  = CH_HELD;
                        cnt_d = SAT;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            CH_HELD: begin
                if (clr_req)     st_d = smp_hi ? CH_WATCH : CH_CLR_PEND;
                else if (smp_hi) st_d = CH_RELEASED;
            end
            CH_RELEASED: begin
                if (clr_req) st_d = CH_WATCH;
            end
            CH_CLR_PEND: begin
                if (smp_hi) st_d = CH_WATCH;
            end
            default: st_d = CH_WATCH;
        endcase
        if ((st_q != CH_WATCH) && (st_d == CH_WATCH)) cnt_d = '0;
    end

    // Outputs.
    always_comb begin
        flag = (st_q != CH_WATCH);
    end

endmodule

// File: rtl/odr_detect.sv
module odr_detect
    import odr_pkg::*;
#(
    parameter int N_PINS  = 4,
    parameter int RUN_LEN = 16,
    parameter int DIV_A   = 8,
    parameter int DIV_B   = 16,
    parameter int DIV_C   = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_PINS-1:0]     req_n,
    input  logic                  reg_rd,
    input  logic                  reg_wr,
    input  logic [4*N_PINS-1:0]   reg_wdata,
    output logic [4*N_PINS-1:0]   reg_rdata,
    output logic                  irq,
    output logic                  hiz_req
);
    localparam int REG_W    = 4 * N_PINS;
    localparam int EN_BIT   = N_PINS;
    localparam int MODE_LSB = 2 * N_PINS;

    logic [N_PINS-1:0]      pin_s;
    logic [2:0]             stb;
    logic [N_PINS-1:0]      flag_w, arm_q, sel_strb, mode_chg, clr_req;
    logic [N_PINS-1:0][1:0] mode_q;
    logic [2*N_PINS-1:0]    mode_flat;
    logic                   en_q;

    odr_sync #(.W(N_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_n),
        .q     (pin_s)
    );

    odr_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (stb)
    );

    for (genvar i = 0; i < N_PINS; i++) begin : g_ch
        assign mode_chg[i] = reg_wr && !flag_w[i]
                             && (reg_wdata[MODE_LSB+2*i +: 2] != mode_q[i]);
        assign clr_req[i]  = reg_wr && !reg_wdata[i] && arm_q[i] && flag_w[i];
        assign mode_flat[2*i +: 2] = mode_q[i];

        odr_channel #(.RUN_LEN(RUN_LEN)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode_q[i]),
            .mode_chg (mode_chg[i]),
            .pin_s    (pin_s[i]),
            .stb      (stb),
            .clr_req  (clr_req[i]),
            .flag     (flag_w[i]),
            .smp_stb  (sel_strb[i])
        );
    end

    // Control/status word: enable, modes, and per-flag read arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= '0;
            arm_q  <= '0;
        end else if (reg_wr) begin
            en_q  <= reg_wdata[EN_BIT];
            arm_q <= '0;
            for (int i = 0; i < N_PINS; i++) begin
                if (mode_chg[i]) mode_q[i] <= reg_wdata[MODE_LSB+2*i +: 2];
            end
        end else if (reg_rd) begin
            arm_q <= flag_w;
        end
    end

    always_comb begin
        reg_rdata = '0;
        reg_rdata[N_PINS-1:0] = flag_w;
        reg_rdata[EN_BIT]     = en_q;
        for (int i = 0; i < N_PINS; i++) begin
            reg_rdata[MODE_LSB+2*i +: 2] = mode_q[i];
        end
    end

    assign hiz_req = |flag_w;
    assign irq     = en_q & (|flag_w);

endmodule

// File: rtl/odr_detect_chk.sv
module odr_detect_chk #(
    parameter int N_PINS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [4*N_PINS-1:0]   reg_wdata,
    input logic [N_PINS-1:0]     flag_w,
    input logic [N_PINS-1:0]     arm_q,
    input logic [N_PINS-1:0]     sel_strb,
    input logic [2*N_PINS-1:0]   mode_flat,
    input logic                  irq,
    input logic                  hiz_req
);
    // R7/R8: an interrupt implies an active high-impedance request.
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> hiz_req);

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        // R3: a filtered flag can only rise right after a sample strobe.
        a_r3_level_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(flag_w[i]) && (mode_flat[2*i +: 2] != 2'b00)) |-> $past(sel_strb[i]));

        // R5: an edge-mode flag survives a write without prior read.
        a_r5_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && !arm_q[i] && flag_w[i] && (mode_flat[2*i +: 2] == 2'b00))
            |=> flag_w[i]);

        // R5: an armed write of 0 in edge mode clears at once.
        a_r5_armed_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && !reg_wdata[i] && arm_q[i] && flag_w[i]
             && (mode_flat[2*i +: 2] == 2'b00)) |=> !flag_w[i]);

        // R10: the mode field cannot change while the flag is set.
        a_r10_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
            $past(flag_w[i]) |-> $stable(mode_flat[2*i +: 2]));
    end

endmodule

bind odr_detect odr_detect_chk #(.N_PINS(N_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .flag_w    (flag_w),
    .arm_q     (arm_q),
    .sel_strb  (sel_strb),
    .mode_flat (mode_flat),
    .irq       (irq),
    .hiz_req   (hiz_req)
);

// File: tb/test_odr_detect.sv
`timescale 1ns/1ps
module test_odr_detect;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_n = 4'hF;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, hiz_req;

    int nvec = 0;
    int nfail = 0;
    logic [7:0] sh_mode = '0;
    logic       sh_en = 1'b0;
    logic [15:0] d;

    always #2 clk = ~clk;

    odr_detect i_odr_detect (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .hiz_req(hiz_req)
    );

    // Table: mode on pin 0, low duration in cycles, expected flag.
    localparam int NV = 8;
    localparam logic [1:0] V_MODE [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b11};
    localparam int         V_LOW  [NV] = '{6, 1, 115, 140, 235, 275, 1900, 2200};
    localparam logic       V_EXP  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(output logic [15:0] v);
        @(negedge clk);
        reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_mode(input int pin, input logic [1:0] m);
        sh_mode[2*pin +: 2] = m;
        reg_write({sh_mode, 3'b000, sh_en, 4'hF});
    endtask

    task automatic clear_flag(input int pin);
        logic [15:0] t;
        logic [3:0]  f;
        reg_read(t);
        f = 4'hF;
        f[pin] = 1'b0;
        reg_write({sh_mode, 3'b000, sh_en, f});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog (all requirements): run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        cycles(5);
        rst_n = 1'b1;
        cycles(2);

        // R1 reset state
        reg_read(d);
        check(d, 16'h0000, "R1 word after reset");
        check(irq, 0, "R1 irq after reset");
        check(hiz_req, 0, "R1 hiz after reset");

        // Table walk on pin 0: R2 edge mode, R3 filtered modes
        for (int v = 0; v < NV; v++) begin
            set_mode(0, V_MODE[v]);
            req_n[0] = 1'b0;
            cycles(V_LOW[v]);
            req_n[0] = 1'b1;
            cycles(4);
            reg_read(d);
            check(d[0], V_EXP[v], (V_MODE[v] == 2'b00) ? "R2 edge flag" : "R3 filtered flag");
            cycles(300);
            clear_flag(0);
            cycles(2);
            reg_read(d);
            check(d[0], 0, "R5 clear after read");
        end
        set_mode(0, 2'b00);

        // R9 reserved bits and R5 write-1 has no effect; enable set
        reg_write(16'h00FF);
        sh_en = 1'b1;
        reg_read(d);
        check(d, 16'h0010, "R9 reserved read 0 / R5 write-1 no set");

        // R2 + R7: edge flag on pin 2 raises irq and hiz
        req_n[2] = 1'b0; cycles(2); req_n[2] = 1'b1; cycles(4);
        check(hiz_req, 1, "R8 hiz with flag");
        check(irq, 1, "R7 irq with enable");

        // R5: write 0 without prior read leaves flag set
        reg_write({sh_mode, 3'b000, sh_en, 4'b1011});
        cycles(2);
        check(hiz_req, 1, "R5 unarmed write keeps flag");

        // R10: mode write ignored while flagged
        reg_write({sh_mode | 8'b0001_0000, 3'b000, sh_en, 4'hF});
        reg_read(d);
        check(d[13:12], 2'b00, "R10 mode locked while flagged");
        check(d[2], 1, "R5 flag still set");

        // R7: enable off masks irq only
        sh_en = 1'b0;
        reg_write({sh_mode, 3'b000, sh_en, 4'hF});
        cycles(1);
        check(irq, 0, "R7 irq masked");
        check(hiz_req, 1, "R8 hiz independent of enable");
        sh_en = 1'b1;
        reg_write({sh_mode, 3'b000, sh_en, 4'hF});

        // R8: armed clear drops hiz at once
        clear_flag(2);
        check(hiz_req, 0, "R8 hiz falls with last flag");
        check(irq, 0, "R7 irq low with no flag");

        // R8 with two flags
        req_n[0] = 1'b0; req_n[2] = 1'b0; cycles(2);
        req_n[0] = 1'b1; req_n[2] = 1'b1; cycles(4);
        reg_read(d);
        check(d[3:0], 4'b0101, "R2 two edge flags");
        clear_flag(0);
        check(hiz_req, 1, "R8 hiz held by remaining flag");
        clear_flag(2);
        check(hiz_req, 0, "R8 hiz after last clear");

        // R6: clear while pin still low stays pending
        set_mode(1, 2'b01);
        req_n[1] = 1'b0;
        cycles(150);
        clear_flag(1);
        cycles(40);
        reg_read(d);
        check(d[1], 1, "R6 clear pending while low");
        req_n[1] = 1'b1;
        cycles(20);
        reg_read(d);
        check(d[1], 0, "R6 pending clear completes on high sample");

        // R4: high sample restarts the count
        set_mode(3, 2'b01);
        req_n[3] = 1'b0; cycles(100);
        req_n[3] = 1'b1; cycles(12);
        req_n[3] = 1'b0; cycles(100);
        req_n[3] = 1'b1; cycles(4);
        reg_read(d);
        check(d[3], 0, "R4 count restarted by high sample");

        // R10: mode change accepted while flag clear
        reg_read(d);
        check(d[15:14], 2'b01, "R10 mode written while clear");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule